// File: doc/BRIEF.md
# Debounced Decimal Tuning Counter

This block holds the operator's tuning setting as a short chain of decimal digits, the form a programmable frequency divider takes on its program inputs. Each accepted step moves the setting by exactly one least-significant count, so the synthesized output moves by one reference step. The operator drives it with two push buttons (raise and lower) or with a two-phase rotary encoder dial. All four mechanical inputs are synchronized and debounced before they can change the count.

The digits are carried as packed BCD nibbles and are also decoded to seven-segment patterns, one per digit, so the displayed number is the tuning setting itself. A digit that passes 9 while counting up goes to 0 and raises the next digit. A digit that passes 0 while counting down goes to 9 and lowers the next digit. The whole count stops at its top value and at zero and never wraps. Debounce length is set at run time in units of an external sample strobe.

Top module: `tune_bcd_counter`

## Requirements
- R1: While reset is high and in the first cycle after it falls, every digit reads 0 and every display field shows the pattern for 0.
- R2: A debounced rising edge of the raise button adds one to the count. Holding the button down adds nothing further until it is released and pressed again.
- R3: A debounced rising edge of the lower button subtracts one from the count.
- R4: Counting up, a digit at 9 goes to 0 and the next higher digit goes up by one (for example 009 to 010 and 099 to 100).
- R5: Counting down, a digit at 0 goes to 9 and the next higher digit goes down by one (for example 010 to 009 and 100 to 099).
- R6: With every digit at 9, a raise request leaves the count unchanged.
- R7: With every digit at 0, a lower request leaves the count unchanged.
- R8: An input change is accepted only after the synchronized input has differed from its accepted level on `db_len` consecutive sample strobes (`db_len` of 0 acts as 1). A shorter pulse or a bounce is ignored.
- R9: Encoder input, written as (enc_a, enc_b), adds one for the full cycle 00, 10, 11, 01, 00 and subtracts one for the reverse cycle 00, 01, 11, 10, 00. The count changes on the return to 00.
- R10: Encoder motion that returns to 00 without completing a full cycle in one direction leaves the count unchanged.
- R11: Each display field is 7 bits wide, bit 0 segment a through bit 6 segment g, active high. The patterns for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R12: Every digit always holds a value from 0 to 9, and the decimal value changes by at most one per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Debounce sample strobe |
| db_len | input | DB_W (4) | Number of strobes an input must stay changed before it is accepted |
| btn_up | input | 1 | Raise push button, active high |
| btn_dn | input | 1 | Lower push button, active high |
| enc_a | input | 1 | Encoder phase A |
| enc_b | input | 1 | Encoder phase B |
| digits_o | output | 4*NDIG (12) | BCD digits, least significant digit in bits 3:0 |
| seg_o | output | 7*NDIG (21) | Seven-segment patterns, digit i in bits 7i+6:7i |

## Verification
Counting is driven by single button presses, by presses held far longer than the debounce window, and by bursts of short pulses before a steady press. The first two show that only the edge counts and the third shows that bounce is removed. Forward and reverse encoder cycles are run, and so are half-cycle jiggles that return to rest, which separate a correct full-cycle detent decoder from one that counts each transition. Directed walks across the 9 to 0 and 0 to 9 digit boundaries, and past both ends of the range, separate the decimal carry and borrow and the saturation from binary counting or wrapping. A seeded random mix of all of these is checked against a decimal reference model after every operation.

// File: rtl/tune_pkg.sv
package tune_pkg;

    typedef logic [3:0] bcd_t;
    typedef logic [1:0] quad_t;

    typedef struct packed {
        logic up;
        logic dn;
    } step_req_t;

    localparam int SYNC_STAGES = 2;

    function automatic logic [6:0] seg_encode(bcd_t d);
        logic [6:0] s;
        case (d)
            4'd0: s = 7'h3F;
            4'd1: s = 7'h06;
            4'd2: s = 7'h5B;
            4'd3: s = 7'h4F;
            4'd4: s = 7'h66;
            4'd5: s = 7'h6D;
            4'd6: s = 7'h7D;
            4'd7: s = 7'h07;
            4'd8: s = 7'h7F;
            4'd9: s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

    function automatic logic quad_fwd(quad_t prev, quad_t cur);
        return (prev == 2'b00 && cur == 2'b10) || (prev == 2'b10 && cur == 2'b11) ||
               (prev == 2'b11 && cur == 2'b01) || (prev == 2'b01 && cur == 2'b00);
    endfunction

    function automatic logic quad_rev(quad_t prev, quad_t cur);
        return quad_fwd(cur, prev);
    endfunction

endpackage

// File: rtl/tune_debounce.sv
module tune_debounce #(
    parameter int W    = 4,
    parameter int DB_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic [DB_W-1:0] db_len,
    input  logic [W-1:0]    raw,
    output logic [W-1:0]    clean
);
    import tune_pkg::*;

    localparam int CW = DB_W + 1;

    logic [CW-1:0] limit;
    assign limit = (db_len == '0) ? CW'(1) : {1'b0, db_len};

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [SYNC_STAGES-1:0] sync_q;
        logic [CW-1:0]          cnt_q;
        logic                   level_q;
        logic                   sampled;

        assign sampled = sync_q[SYNC_STAGES-1];

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q  <= '0;
                cnt_q   <= '0;
                level_q <= 1'b0;
            end else begin
                sync_q <= {sync_q[SYNC_STAGES-2:0], raw[i]};
                if (sampled == level_q) begin
                    cnt_q <= '0;
                end else if (tick) begin
                    if (cnt_q + CW'(1) >= limit) begin
                        level_q <= sampled;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
            end
        end

        assign clean[i] = level_q;
    end

endmodule

// File: rtl/tune_quad_dir.sv
module tune_quad_dir (
    input  logic clk,
    input  logic rst,
    input  logic a,
    input  logic b,
    output logic up_p,
    output logic dn_p
);
    import tune_pkg::*;

    quad_t             prev_q;
    quad_t             cur;
    logic signed [3:0] acc_q;
    logic signed [3:0] acc_n;

    assign cur = {a, b};

    always_comb begin
        acc_n = acc_q;
        if (quad_fwd(prev_q, cur))
            acc_n = acc_q + 4'sd1;
        else if (quad_rev(prev_q, cur))
            acc_n = acc_q - 4'sd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 2'b00;
            acc_q  <= '0;
            up_p   <= 1'b0;
            dn_p   <= 1'b0;
        end else begin
            up_p   <= 1'b0;
            dn_p   <= 1'b0;
            prev_q <= cur;
            if (cur != prev_q) begin
                if (cur == 2'b00) begin
                    up_p  <= (acc_n == 4'sd4);
                    dn_p  <= (acc_n == -4'sd4);
                    acc_q <= '0;
                end else begin
                    acc_q <= acc_n;
                end
            end
        end
    end

endmodule

// File: rtl/tune_bcd_chain.sv
module tune_bcd_chain #(
    parameter int NDIG = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  tune_pkg::step_req_t req,
    output logic [4*NDIG-1:0] digits
);
    import tune_pkg::*;

    bcd_t        dig_q [NDIG];
    logic [NDIG:0] low_nines;
    logic [NDIG:0] low_zeros;
    logic        go_up;
    logic        go_dn;

    assign low_nines[0] = 1'b1;
    assign low_zeros[0] = 1'b1;

    for (genvar i = 0; i < NDIG; i++) begin : g_chain
        assign low_nines[i+1] = low_nines[i] & (dig_q[i] == 4'd9);
        assign low_zeros[i+1] = low_zeros[i] & (dig_q[i] == 4'd0);
    end

    assign go_up = req.up & ~req.dn & ~low_nines[NDIG];
    assign go_dn = req.dn & ~req.up & ~low_zeros[NDIG];

    for (genvar i = 0; i < NDIG; i++) begin : g_digit
        always_ff @(posedge clk) begin
            if (rst) begin
                dig_q[i] <= 4'd0;
            end else if (go_up && low_nines[i]) begin
                dig_q[i] <= (dig_q[i] == 4'd9) ? 4'd0 : dig_q[i] + 4'd1;
            end else if (go_dn && low_zeros[i]) begin
                dig_q[i] <= (dig_q[i] == 4'd0) ? 4'd9 : dig_q[i] - 4'd1;
            end
        end
        assign digits[4*i +: 4] = dig_q[i];
    end

endmodule

// File: rtl/tune_bcd_counter.sv
module tune_bcd_counter #(
    parameter int NDIG = 3,
    parameter int DB_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [DB_W-1:0]   db_len,
    input  logic              btn_up,
    input  logic              btn_dn,
    input  logic              enc_a,
    input  logic              enc_b,
    output logic [4*NDIG-1:0] digits_o,
    output logic [7*NDIG-1:0] seg_o
);
    import tune_pkg::*;

    localparam int NIN = 4;

    logic [NIN-1:0] clean;
    logic           up_lvl_q;
    logic           dn_lvl_q;
    logic           enc_up;
    logic           enc_dn;
    step_req_t      req;

    tune_debounce #(.W(NIN), .DB_W(DB_W)) u_db (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .db_len (db_len),
        .raw    ({enc_b, enc_a, btn_dn, btn_up}),
        .clean  (clean)
    );

    tune_quad_dir u_quad (
        .clk  (clk),
        .rst  (rst),
        .a    (clean[2]),
        .b    (clean[3]),
        .up_p (enc_up),
        .dn_p (enc_dn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            up_lvl_q <= 1'b0;
            dn_lvl_q <= 1'b0;
        end else begin
            up_lvl_q <= clean[0];
            dn_lvl_q <= clean[1];
        end
    end

    assign req.up = (clean[0] & ~up_lvl_q) | enc_up;
    assign req.dn = (clean[1] & ~dn_lvl_q) | enc_dn;

    tune_bcd_chain #(.NDIG(NDIG)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .digits (digits_o)
    );

    for (genvar i = 0; i < NDIG; i++) begin : g_seg
        assign seg_o[7*i +: 7] = seg_encode(digits_o[4*i +: 4]);
    end

endmodule

// File: rtl/tune_bcd_counter_chk.sv
module tune_bcd_counter_chk #(
    parameter int NDIG = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [4*NDIG-1:0] digits,
    input logic [7*NDIG-1:0] seg
);
    function automatic int pow10(int n);
        int r = 1;
        for (int k = 0; k < n; k++) r = r * 10;
        return r;
    endfunction

    localparam int MAXV = pow10(NDIG) - 1;

    int   cur;
    logic primed;

    always_comb begin
        cur = 0;
        for (int k = NDIG - 1; k >= 0; k--)
            cur = cur * 10 + int'(digits[4*k +: 4]);
    end

    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    p_reset_zero_r1: assert property (@(posedge clk) rst |=> cur == 0);

    p_single_step_r12: assert property (@(posedge clk) disable iff (rst)
        primed |-> (cur == $past(cur) || cur == $past(cur) + 1 || cur + 1 == $past(cur)));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(cur) == MAXV && cur != MAXV) |-> cur == MAXV - 1);

    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(cur) == 0 && cur != 0) |-> cur == 1);

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        p_digit_range_r12: assert property (@(posedge clk) disable iff (rst)
            digits[4*i +: 4] <= 4'd9);
        p_seg_lit_r11: assert property (@(posedge clk) disable iff (rst)
            seg[7*i +: 7] != 7'h00);
        p_seg_eight_r11: assert property (@(posedge clk) disable iff (rst)
            (digits[4*i +: 4] == 4'd8) |-> seg[7*i +: 7] == 7'h7F);
    end

endmodule

bind tune_bcd_counter tune_bcd_counter_chk #(.NDIG(NDIG)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .digits (digits_o),
    .seg    (seg_o)
);

// File: tb/tune_bcd_counter_bench.sv
module tune_bcd_counter_bench;

    localparam int NDIG = 3;
    localparam int DB_W = 4;
    localparam int MAXV = 999;
    localparam int HOLD = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic              tick;
    logic [DB_W-1:0]   db_len;
    logic              btn_up, btn_dn, enc_a, enc_b;
    logic [4*NDIG-1:0] digits_o;
    logic [7*NDIG-1:0] seg_o;

    int model;
    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    tune_bcd_counter #(.NDIG(NDIG), .DB_W(DB_W)) u_tune_bcd_counter (
        .clk(clk), .rst(rst), .tick(tick), .db_len(db_len),
        .btn_up(btn_up), .btn_dn(btn_dn), .enc_a(enc_a), .enc_b(enc_b),
        .digits_o(digits_o), .seg_o(seg_o)
    );

    initial begin
        tick = 1'b0;
        forever begin
            @(negedge clk);
            tick = ~tick;
        end
    end

    function automatic logic [6:0] exp_seg(int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic logic [4*NDIG-1:0] exp_digits(int v);
        logic [4*NDIG-1:0] r;
        for (int k = 0; k < NDIG; k++) begin
            r[4*k +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    function automatic logic [7*NDIG-1:0] exp_segs(int v);
        logic [7*NDIG-1:0] r;
        for (int k = 0; k < NDIG; k++) begin
            r[7*k +: 7] = exp_seg(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    task automatic check_state(string tag);
        n_checks++;
        if (digits_o !== exp_digits(model)) begin
            n_fail++;
            $display("FAIL %s digits actual %h expected %h", tag, digits_o, exp_digits(model));
        end
        n_checks++;
        if (seg_o !== exp_segs(model)) begin
            n_fail++;
            $display("FAIL R11 (%s) segments actual %h expected %h", tag, seg_o, exp_segs(model));
        end
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press_up();
        btn_up = 1'b1; wait_cycles(HOLD);
        btn_up = 1'b0; wait_cycles(HOLD);
        if (model < MAXV) model++;
    endtask

    task automatic press_dn();
        btn_dn = 1'b1; wait_cycles(HOLD);
        btn_dn = 1'b0; wait_cycles(HOLD);
        if (model > 0) model--;
    endtask

    task automatic enc_to(logic a, logic b);
        enc_a = a; enc_b = b; wait_cycles(HOLD);
    endtask

    task automatic enc_fwd();
        enc_to(1, 0); enc_to(1, 1); enc_to(0, 1); enc_to(0, 0);
        if (model < MAXV) model++;
    endtask

    task automatic enc_rev();
        enc_to(0, 1); enc_to(1, 1); enc_to(1, 0); enc_to(0, 0);
        if (model > 0) model--;
    endtask

    task automatic enc_jiggle();
        enc_to(1, 0); enc_to(0, 0); enc_to(0, 1); enc_to(1, 1);
        enc_to(0, 1); enc_to(0, 0);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; db_len = 4'd3;
        btn_up = 0; btn_dn = 0; enc_a = 0; enc_b = 0;
        model = 0;
        wait_cycles(4);
        check_state("R1 in reset");
        rst = 1'b0;
        wait_cycles(1);
        check_state("R1 after reset");

        // R8: short glitch ignored
        btn_up = 1'b1; wait_cycles(3); btn_up = 1'b0; wait_cycles(20);
        check_state("R8 glitch");
        // R8: bounce burst then steady press counts once
        for (int k = 0; k < 4; k++) begin
            btn_up = 1'b1; wait_cycles(2); btn_up = 1'b0; wait_cycles(2);
        end
        press_up();
        check_state("R8 bounce");
        // R2: long hold counts once
        btn_up = 1'b1; wait_cycles(120); btn_up = 1'b0; wait_cycles(HOLD);
        model++;
        check_state("R2 hold");
        press_dn(); press_dn();
        check_state("R3 down");

        // R9 / R10 encoder
        enc_fwd(); check_state("R9 forward");
        enc_fwd(); check_state("R9 forward again");
        enc_rev(); check_state("R9 reverse");
        enc_jiggle(); check_state("R10 jiggle");

        // R4 / R5 carry and borrow at units
        while (model < 9) press_up();
        check_state("R4 at 9");
        press_up(); check_state("R4 9 to 10");
        press_dn(); check_state("R5 10 to 9");
        while (model < 99) press_up();
        press_up(); check_state("R4 99 to 100");
        press_dn(); check_state("R5 100 to 99");
        press_up();

        // R6 saturation at top
        while (model < MAXV) press_up();
        check_state("R6 at top");
        press_up(); check_state("R6 stays at top");
        enc_fwd(); check_state("R6 encoder at top");

        // random mix
        for (int k = 0; k < 150; k++) begin
            case ($urandom_range(0, 4))
                0: press_up();
                1: press_dn();
                2: enc_fwd();
                3: enc_rev();
                default: enc_jiggle();
            endcase
            check_state("R12 random");
        end

        // R7 saturation at bottom
        while (model > 0) press_dn();
        check_state("R7 at zero");
        press_dn(); check_state("R7 stays at zero");
        enc_rev(); check_state("R7 encoder at zero");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule